// File: doc/BRIEF.md
# Dual-Issue Load-Use Stall Detector

This block decides, within the decode cycle, whether the two instructions in a two-wide in-order decode group may issue. The pipeline it serves forwards every result except a load's data. The only hazard it therefore looks for is a consumer that needs a value a load is still fetching. It compares every used source register of both decode slots against the destination of each load in the two execute/memory slots. The younger decode slot is also compared against the older one in its own group, because two instructions that issue together cannot forward to each other.

The block raises one stall for the older slot and one for the younger slot. The two stalls are asymmetric. A stalled older slot holds the whole group, but a stalled younger slot lets the older instruction go. A mode input chooses what fills the gap in that second case. In rigid mode, the next fetch group waits until the younger instruction has issued. In fluid mode, the younger instruction moves into the older slot and the first instruction of the next group joins it.

The block has no clock and holds no state. All outputs are combinational functions of the current inputs. It has no data stream and no valid/ready handshake. Every pin is a plain control level, and back-pressure leaves the block only as the stall outputs and the steering code.

Top module: `hzd_dual_stall`

## Requirements
- R1: The older stall is 1 when the older decode slot is valid and one of its used sources equals the destination of a valid execute/memory slot whose class code is load (2'b01).
- R2: Either execute/memory slot (0 or 1) alone is enough to stall, and a match on the second source counts the same as a match on the first.
- R3: The younger stall is 1 when the younger slot is valid and one of its used sources matches a valid load destination in either execute/memory slot.
- R4: The younger stall is 1 when the younger slot is valid and one of its used sources equals the destination of the valid older decode slot, whatever instruction the older slot holds.
- R5: When the older stall is 1 and the younger slot is valid, the younger stall is also 1.
- R6: A younger-slot dependence, on the older slot or on a load, never raises the older stall.
- R7: Register 0 never forms a dependence. A source whose used flag is 0 never matches.
- R8: An invalid execute/memory slot never causes a stall. An invalid decode slot never reports a stall. An invalid older slot never forms an intra-group dependence. With all inputs at zero, every output is zero.
- R9: Execute/memory classes ALU (2'b00), store (2'b10) and branch (2'b11) never cause a stall.
- R10: The steering code is 2'b00 (advance both) when neither stall is set. It is 2'b01 (hold the group) whenever the older stall is set.
- R11: In rigid mode (mode_fluid=0), when only the younger slot stalls, the steering code is 2'b10. The older instruction issues, the younger stays in place and fetch waits.
- R12: In fluid mode (mode_fluid=1), when only the younger slot stalls, the steering code is 2'b11. The younger instruction moves to the older slot and the next group's first instruction fills the younger slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_fluid | input | 1 | 1 selects fluid group advance, 0 selects rigid |
| dx0_valid | input | 1 | Older decode slot holds an instruction |
| dx0_rd | input | REG_W | Older slot destination register |
| dx0_rs1 | input | REG_W | Older slot first source register |
| dx0_rs1_used | input | 1 | Older slot first source is read |
| dx0_rs2 | input | REG_W | Older slot second source register |
| dx0_rs2_used | input | 1 | Older slot second source is read |
| dx1_valid | input | 1 | Younger decode slot holds an instruction |
| dx1_rs1 | input | REG_W | Younger slot first source register |
| dx1_rs1_used | input | 1 | Younger slot first source is read |
| dx1_rs2 | input | REG_W | Younger slot second source register |
| dx1_rs2_used | input | 1 | Younger slot second source is read |
| xm0_valid | input | 1 | Execute/memory slot 0 holds an instruction |
| xm0_class | input | 2 | Slot 0 class: 00 ALU, 01 load, 10 store, 11 branch |
| xm0_rd | input | REG_W | Slot 0 destination register |
| xm1_valid | input | 1 | Execute/memory slot 1 holds an instruction |
| xm1_class | input | 2 | Slot 1 class, same encoding |
| xm1_rd | input | REG_W | Slot 1 destination register |
| stall_old | output | 1 | Older decode slot must not issue |
| stall_yng | output | 1 | Younger decode slot must not issue |
| steer | output | 2 | Group steering: 00 advance, 01 hold, 10 drain younger, 11 slide up |

## Verification
The checks assume the input fields are stable and well formed. A destination of 0 stands for "no write", and the class field uses only the four listed codes. Fields of invalid slots may hold any value.

The stimulus draws register numbers from a small range so that matches are frequent. It draws valid bits, used flags and class codes freely over their legal values, which includes deliberately matching fields in invalid slots. Directed cases add the register-0, unused-source and non-load-class corner cases.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    OPC_ALU    = 2'b00,
    OPC_LOAD   = 2'b01,
    OPC_STORE  = 2'b10,
    OPC_BRANCH = 2'b11
  } opc_e;

  typedef enum logic [1:0] {
    STEER_ADVANCE = 2'b00,
    STEER_HOLD    = 2'b01,
    STEER_DRAIN   = 2'b10,
    STEER_SLIDE   = 2'b11
  } steer_e;

endpackage

// File: rtl/hzd_src_match.sv
// One consumer source against one producer destination.
module hzd_src_match #(
  parameter int REG_W = 5
) (
  input  logic             src_used,
  input  logic [REG_W-1:0] src,
  input  logic             prod_live,
  input  logic [REG_W-1:0] prod_rd,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  always_comb begin
    hit = src_used && prod_live && (prod_rd != ZERO_REG) && (src == prod_rd);
  end
endmodule

// File: rtl/hzd_slot_check.sv
// One decode slot checked against a set of producers: NUM_SRC x NUM_PROD matches.
module hzd_slot_check #(
  parameter int REG_W    = 5,
  parameter int NUM_SRC  = 2,
  parameter int NUM_PROD = 2
) (
  input  logic                           slot_valid,
  input  logic [NUM_SRC-1:0]             src_used,
  input  logic [NUM_SRC-1:0][REG_W-1:0]  src,
  input  logic [NUM_PROD-1:0]            prod_live,
  input  logic [NUM_PROD-1:0][REG_W-1:0] prod_rd,
  output logic                           stall
);
  localparam int NUM_CMP = NUM_SRC * NUM_PROD;

  logic [NUM_CMP-1:0] hits;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
      hzd_src_match #(.REG_W(REG_W)) u_match (
        .src_used (src_used[s]),
        .src      (src[s]),
        .prod_live(prod_live[p]),
        .prod_rd  (prod_rd[p]),
        .hit      (hits[s*NUM_PROD + p])
      );
    end
  end

  always_comb begin
    stall = slot_valid && (|hits);
  end
endmodule

// File: rtl/hzd_steer.sv
// Maps the two stall levels and the advance mode onto the group steering code.
module hzd_steer (
  input  logic        mode_fluid,
  input  logic        stall_old,
  input  logic        stall_yng,
  output logic [1:0]  steer
);
  import hzd_pkg::*;

  steer_e sel;

  always_comb begin
    if (stall_old)       sel = STEER_HOLD;
    else if (!stall_yng) sel = STEER_ADVANCE;
    else if (mode_fluid) sel = STEER_SLIDE;
    else                 sel = STEER_DRAIN;
    steer = sel;
  end
endmodule

// File: rtl/hzd_dual_stall.sv
module hzd_dual_stall #(
  parameter int REG_W = 5
) (
  input  logic             mode_fluid,
  input  logic             dx0_valid,
  input  logic [REG_W-1:0] dx0_rd,
  input  logic [REG_W-1:0] dx0_rs1,
  input  logic             dx0_rs1_used,
  input  logic [REG_W-1:0] dx0_rs2,
  input  logic             dx0_rs2_used,
  input  logic             dx1_valid,
  input  logic [REG_W-1:0] dx1_rs1,
  input  logic             dx1_rs1_used,
  input  logic [REG_W-1:0] dx1_rs2,
  input  logic             dx1_rs2_used,
  input  logic             xm0_valid,
  input  logic [1:0]       xm0_class,
  input  logic [REG_W-1:0] xm0_rd,
  input  logic             xm1_valid,
  input  logic [1:0]       xm1_class,
  input  logic [REG_W-1:0] xm1_rd,
  output logic             stall_old,
  output logic             stall_yng,
  output logic [1:0]       steer
);
  import hzd_pkg::*;

  localparam int NUM_SRC  = 2;
  localparam int XM_SLOTS = 2;
  localparam int YNG_PROD = XM_SLOTS + 1;

  logic [XM_SLOTS-1:0]             xm_live;
  logic [XM_SLOTS-1:0][REG_W-1:0]  xm_rd;
  logic [YNG_PROD-1:0]             yp_live;
  logic [YNG_PROD-1:0][REG_W-1:0]  yp_rd;
  logic [NUM_SRC-1:0][REG_W-1:0]   o_src, y_src;
  logic [NUM_SRC-1:0]              o_used, y_used;
  logic                            old_dep, yng_dep;

  always_comb begin
    // Only a valid load in execute/memory cannot be forwarded in time.
    xm_live[0] = xm0_valid && (xm0_class == OPC_LOAD);
    xm_live[1] = xm1_valid && (xm1_class == OPC_LOAD);
    xm_rd[0]   = xm0_rd;
    xm_rd[1]   = xm1_rd;
    // Younger slot also sees the older decode slot as a producer of any class.
    yp_live    = {dx0_valid, xm_live};
    yp_rd      = {dx0_rd, xm_rd};
    o_src      = {dx0_rs2, dx0_rs1};
    o_used     = {dx0_rs2_used, dx0_rs1_used};
    y_src      = {dx1_rs2, dx1_rs1};
    y_used     = {dx1_rs2_used, dx1_rs1_used};
  end

  hzd_slot_check #(.REG_W(REG_W), .NUM_SRC(NUM_SRC), .NUM_PROD(XM_SLOTS)) u_old (
    .slot_valid(dx0_valid),
    .src_used  (o_used),
    .src       (o_src),
    .prod_live (xm_live),
    .prod_rd   (xm_rd),
    .stall     (old_dep)
  );

  hzd_slot_check #(.REG_W(REG_W), .NUM_SRC(NUM_SRC), .NUM_PROD(YNG_PROD)) u_yng (
    .slot_valid(dx1_valid),
    .src_used  (y_used),
    .src       (y_src),
    .prod_live (yp_live),
    .prod_rd   (yp_rd),
    .stall     (yng_dep)
  );

  always_comb begin
    stall_old = old_dep;
    stall_yng = yng_dep || (dx1_valid && old_dep);
  end

  hzd_steer u_steer (
    .mode_fluid(mode_fluid),
    .stall_old (stall_old),
    .stall_yng (stall_yng),
    .steer     (steer)
  );
endmodule

// File: rtl/hzd_dual_stall_chk.sv
module hzd_dual_stall_chk #(
  parameter int REG_W = 5
) (
  input logic             mode_fluid,
  input logic             dx0_valid,
  input logic [REG_W-1:0] dx0_rd,
  input logic [REG_W-1:0] dx0_rs1,
  input logic             dx0_rs1_used,
  input logic [REG_W-1:0] dx0_rs2,
  input logic             dx0_rs2_used,
  input logic             dx1_valid,
  input logic [REG_W-1:0] dx1_rs1,
  input logic             dx1_rs1_used,
  input logic [REG_W-1:0] dx1_rs2,
  input logic             dx1_rs2_used,
  input logic             xm0_valid,
  input logic [1:0]       xm0_class,
  input logic [REG_W-1:0] xm0_rd,
  input logic             xm1_valid,
  input logic [1:0]       xm1_class,
  input logic [REG_W-1:0] xm1_rd,
  input logic             stall_old,
  input logic             stall_yng,
  input logic [1:0]       steer
);
  import hzd_pkg::*;

  logic any_load, any_load_rd;

  always_comb begin
    any_load    = (xm0_valid && xm0_class == OPC_LOAD) || (xm1_valid && xm1_class == OPC_LOAD);
    any_load_rd = (xm0_valid && xm0_class == OPC_LOAD && xm0_rd != '0) ||
                  (xm1_valid && xm1_class == OPC_LOAD && xm1_rd != '0);

    // R5
    yng_follows_old_chk: assert (!(stall_old && dx1_valid) || stall_yng);
    // R6
    old_needs_load_chk: assert (!stall_old || any_load);
    // R7
    zero_reg_quiet_chk: assert (!stall_old || any_load_rd);
    // R8
    idle_old_quiet_chk: assert (dx0_valid || !stall_old);
    // R8
    idle_yng_quiet_chk: assert (dx1_valid || !stall_yng);
    // R9
    nonload_quiet_chk: assert (any_load || dx0_valid || !stall_yng);
    // R10
    steer_hold_chk: assert (!stall_old || steer == STEER_HOLD);
    // R10
    steer_adv_chk: assert (stall_old || stall_yng || steer == STEER_ADVANCE);
    // R11
    steer_drain_chk: assert (!(!stall_old && stall_yng && !mode_fluid) || steer == STEER_DRAIN);
    // R12
    steer_slide_chk: assert (!(!stall_old && stall_yng && mode_fluid) || steer == STEER_SLIDE);
  end
endmodule

bind hzd_dual_stall hzd_dual_stall_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/hzd_dual_stall_tb.sv
module hzd_dual_stall_tb;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             mode_fluid;
  logic             dx0_valid, dx0_rs1_used, dx0_rs2_used;
  logic [REG_W-1:0] dx0_rd, dx0_rs1, dx0_rs2;
  logic             dx1_valid, dx1_rs1_used, dx1_rs2_used;
  logic [REG_W-1:0] dx1_rs1, dx1_rs2;
  logic             xm0_valid, xm1_valid;
  logic [1:0]       xm0_class, xm1_class;
  logic [REG_W-1:0] xm0_rd, xm1_rd;
  logic             stall_old, stall_yng;
  logic [1:0]       steer;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;

  hzd_dual_stall #(.REG_W(REG_W)) u_dut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic clear_all();
    mode_fluid = 0;
    dx0_valid = 0; dx0_rd = 0; dx0_rs1 = 0; dx0_rs1_used = 0; dx0_rs2 = 0; dx0_rs2_used = 0;
    dx1_valid = 0; dx1_rs1 = 0; dx1_rs1_used = 0; dx1_rs2 = 0; dx1_rs2_used = 0;
    xm0_valid = 0; xm0_class = 0; xm0_rd = 0;
    xm1_valid = 0; xm1_class = 0; xm1_rd = 0;
  endtask

  function automatic logic ld_hit(logic v, logic [1:0] c, logic [REG_W-1:0] rd,
                                  logic u, logic [REG_W-1:0] s);
    return v && (c == 2'b01) && (rd != 0) && u && (s == rd);
  endfunction

  function automatic logic src_hits(logic u1, logic [REG_W-1:0] s1,
                                    logic u2, logic [REG_W-1:0] s2);
    return ld_hit(xm0_valid, xm0_class, xm0_rd, u1, s1) || ld_hit(xm1_valid, xm1_class, xm1_rd, u1, s1) ||
           ld_hit(xm0_valid, xm0_class, xm0_rd, u2, s2) || ld_hit(xm1_valid, xm1_class, xm1_rd, u2, s2);
  endfunction

  function automatic logic m_intra();
    return dx0_valid && dx0_rd != 0 &&
           ((dx1_rs1_used && dx1_rs1 == dx0_rd) || (dx1_rs2_used && dx1_rs2 == dx0_rd));
  endfunction

  function automatic logic m_old();
    return dx0_valid && src_hits(dx0_rs1_used, dx0_rs1, dx0_rs2_used, dx0_rs2);
  endfunction

  function automatic logic m_yng();
    return dx1_valid && (m_old() || m_intra() || src_hits(dx1_rs1_used, dx1_rs1, dx1_rs2_used, dx1_rs2));
  endfunction

  function automatic logic [1:0] m_steer();
    if (m_old()) return 2'b01;
    if (!m_yng()) return 2'b00;
    return mode_fluid ? 2'b11 : 2'b10;
  endfunction

  task automatic check3(string tag, logic e_old, logic e_yng, logic [1:0] e_st);
    @(negedge clk);
    n_checks++;
    if (stall_old !== e_old || stall_yng !== e_yng || steer !== e_st) begin
      n_errors++;
      $display("FAIL %s: actual old=%b yng=%b steer=%b expected old=%b yng=%b steer=%b",
               tag, stall_old, stall_yng, steer, e_old, e_yng, e_st);
    end
  endtask

  task automatic check_model(string tag);
    check3(tag, m_old(), m_yng(), m_steer());
  endtask

  initial begin
    void'($urandom(32'd1234));
    clear_all();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R8: all-zero inputs
    check3("R8 idle", 0, 0, 2'b00);

    // R1 and R5: xm0 load into older rs1, younger valid but independent
    clear_all();
    xm0_valid = 1; xm0_class = 2'b01; xm0_rd = 3;
    dx0_valid = 1; dx0_rs1 = 3; dx0_rs1_used = 1;
    dx1_valid = 1; dx1_rs1 = 9; dx1_rs1_used = 1;
    check3("R1 R5 R10 older load-use", 1, 1, 2'b01);

    // R2: xm1 load into older rs2 only
    clear_all();
    xm1_valid = 1; xm1_class = 2'b01; xm1_rd = 7;
    dx0_valid = 1; dx0_rs2 = 7; dx0_rs2_used = 1;
    check3("R2 slot1 second source", 1, 0, 2'b01);

    // R3, R11: younger on xm1 load, rigid
    clear_all();
    xm1_valid = 1; xm1_class = 2'b01; xm1_rd = 4;
    dx0_valid = 1; dx0_rd = 12; dx0_rs1 = 2; dx0_rs1_used = 1;
    dx1_valid = 1; dx1_rs1 = 4; dx1_rs1_used = 1;
    check3("R3 R6 R11 younger load-use rigid", 0, 1, 2'b10);

    // R4, R6, R12: intra-group on rs2, fluid, no loads anywhere
    clear_all();
    mode_fluid = 1;
    xm0_valid = 1; xm0_class = 2'b00; xm0_rd = 6;
    dx0_valid = 1; dx0_rd = 6;
    dx1_valid = 1; dx1_rs2 = 6; dx1_rs2_used = 1;
    check3("R4 R6 R12 intra-group fluid", 0, 1, 2'b11);

    // R7: destination 0 in a load
    clear_all();
    xm0_valid = 1; xm0_class = 2'b01; xm0_rd = 0;
    dx0_valid = 1; dx0_rs1 = 0; dx0_rs1_used = 1;
    dx1_valid = 1; dx1_rs1 = 0; dx1_rs1_used = 1;
    check3("R7 register zero", 0, 0, 2'b00);

    // R7: unused flag on matching source
    clear_all();
    xm0_valid = 1; xm0_class = 2'b01; xm0_rd = 5;
    dx0_valid = 1; dx0_rd = 8; dx0_rs1 = 5; dx0_rs1_used = 0;
    dx1_valid = 1; dx1_rs2 = 8; dx1_rs2_used = 0;
    check3("R7 unused source", 0, 0, 2'b00);

    // R8: invalid load slot with matching fields
    clear_all();
    xm1_valid = 0; xm1_class = 2'b01; xm1_rd = 5;
    dx0_valid = 1; dx0_rs1 = 5; dx0_rs1_used = 1;
    check3("R8 invalid producer", 0, 0, 2'b00);

    // R8: invalid older slot with matching fields, and no intra-group check
    clear_all();
    xm0_valid = 1; xm0_class = 2'b01; xm0_rd = 5;
    dx0_valid = 0; dx0_rd = 9; dx0_rs1 = 5; dx0_rs1_used = 1;
    dx1_valid = 1; dx1_rs1 = 9; dx1_rs1_used = 1;
    check3("R8 invalid older", 0, 0, 2'b00);

    // R8: invalid younger while older stalls
    clear_all();
    xm0_valid = 1; xm0_class = 2'b01; xm0_rd = 5;
    dx0_valid = 1; dx0_rs1 = 5; dx0_rs1_used = 1;
    dx1_valid = 0; dx1_rs1 = 5; dx1_rs1_used = 1;
    check3("R8 invalid younger", 1, 0, 2'b01);

    // R9: non-load classes never stall
    for (int c = 0; c < 4; c++) begin
      if (c == 1) continue;
      clear_all();
      xm0_valid = 1; xm0_class = c[1:0]; xm0_rd = 10;
      xm1_valid = 1; xm1_class = c[1:0]; xm1_rd = 11;
      dx0_valid = 1; dx0_rs1 = 10; dx0_rs1_used = 1;
      dx1_valid = 1; dx1_rs2 = 11; dx1_rs2_used = 1;
      check3("R9 non-load class", 0, 0, 2'b00);
    end

    // R10: older stall dominates fluid mode
    clear_all();
    mode_fluid = 1;
    xm1_valid = 1; xm1_class = 2'b01; xm1_rd = 2;
    dx0_valid = 1; dx0_rd = 3; dx0_rs2 = 2; dx0_rs2_used = 1;
    dx1_valid = 1; dx1_rs1 = 3; dx1_rs1_used = 1;
    check3("R10 R5 hold in fluid", 1, 1, 2'b01);

    // Random mix against the model
    for (int i = 0; i < 4000; i++) begin
      mode_fluid   = 1'($urandom);
      dx0_valid    = ($urandom % 8) != 0;
      dx0_rd       = REG_W'($urandom % 4);
      dx0_rs1      = REG_W'($urandom % 4);
      dx0_rs1_used = 1'($urandom);
      dx0_rs2      = REG_W'($urandom % 4);
      dx0_rs2_used = 1'($urandom);
      dx1_valid    = ($urandom % 8) != 0;
      dx1_rs1      = REG_W'($urandom % 4);
      dx1_rs1_used = 1'($urandom);
      dx1_rs2      = REG_W'($urandom % 4);
      dx1_rs2_used = 1'($urandom);
      xm0_valid    = 1'($urandom);
      xm0_class    = 2'($urandom);
      xm0_rd       = REG_W'($urandom % 4);
      xm1_valid    = 1'($urandom);
      xm1_class    = 2'($urandom);
      xm1_rd       = REG_W'($urandom % 4);
      if (m_old())        check_model("R1 random older");
      else if (m_intra()) check_model("R4 random intra");
      else if (m_yng())   check_model("R3 random younger");
      else                check_model("R9 random quiet");
    end

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule